// File: doc/BRIEF.md
# Compact Integer Execute Stage

This block is the execute stage for a small set of two-operand integer instructions: add in three forms (register, short 5-bit immediate, 16-bit immediate), bitwise AND in two forms (register and 16-bit immediate), and compare in register and short-immediate forms. Each instruction arrives as a 16-bit leading halfword, plus a trailing halfword that only the 16-bit immediate forms use. The two 32-bit register operand values come with it, already read by the surrounding pipeline. The block returns a writeback packet: a write enable, a destination index and a 32-bit value. It also keeps a four-bit condition flag register.

Instructions enter on a valid/ready handshake and results leave on another. An instruction is taken when `in_valid` and `in_ready` are both high on a rising clock edge. Its packet is presented on the next cycle. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the packet and the flags hold still and no new instruction is taken. Opcodes outside the supported set still produce a packet, but it is marked illegal and writes nothing.

Top module: `exec_unit_top`

## Requirements
- R1: The leading halfword is split as bits 15:11 = destination / second source index, bits 10:5 = 6-bit opcode, bits 4:0 = first source index or 5-bit immediate. Opcode 001110 (register add) writes rs2 + rs1 to the destination.
- R2: Opcode 010010 (short add) writes rs2 + sign-extended bits 4:0 to the destination.
- R3: Opcode 110000 (long add) writes rs1 + sign-extended trailing halfword to the destination.
- R4: Opcode 001010 (register AND) writes rs2 & rs1. Opcode 110110 (long AND) writes rs1 & zero-extended trailing halfword.
- R5: Opcode 001111 computes rs2 − rs1, and opcode 010011 computes rs2 − sign-extended bits 4:0. Both set the flags and drive `out_wr_en` low.
- R6: `out_flags` is {CY, OV, S, Z} in bits 3..0. Add and compare set all four: CY = carry out (add) or borrow (compare); OV = signed overflow; S = result bit 31; Z = result is zero.
- R7: The AND forms clear OV, set S and Z from the result, and leave CY unchanged.
- R8: An instruction whose destination index is 0 drives `out_wr_en` low. Its flags still update.
- R9: Any other opcode raises `out_illegal`, drives `out_wr_en` low and leaves `out_flags` unchanged.
- R10: An instruction is accepted when in_valid && in_ready, and its packet appears with `out_valid` one cycle later. `in_ready` = !out_valid || out_ready. While out_valid && !out_ready, the packet and the flags stay stable.
- R11: Reset (rst_n low, asynchronous) clears `out_valid` and `out_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_hw0 | input | 16 | Leading instruction halfword |
| in_hw1 | input | 16 | Trailing halfword (16-bit immediate) |
| in_rs1_val | input | 32 | Value of the register named by bits 4:0 |
| in_rs2_val | input | 32 | Value of the register named by bits 15:11 |
| out_valid | output | 1 | Writeback packet present |
| out_ready | input | 1 | Consumer takes the packet |
| out_wr_en | output | 1 | Packet writes a register |
| out_wr_idx | output | 5 | Destination register index |
| out_wr_data | output | 32 | Value to write |
| out_illegal | output | 1 | Opcode not supported |
| out_flags | output | 4 | {CY, OV, S, Z} |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 5-bit register indices and 16-bit halfwords. At these widths the carry out of bit 31, signed overflow at the 0x7FFFFFFF/0x80000000 boundary, and the sign and zero extension of 0x8000 and 0xFFFF can all be checked against hand-computed values. Back-pressure is exercised by holding `out_ready` low while a second instruction waits, which shows that neither the held packet nor the flags move until the slot drains.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned OPW = 6;

  localparam logic [OPW-1:0] OP_ADD_R  = 6'b001110;
  localparam logic [OPW-1:0] OP_ADD_S  = 6'b010010;
  localparam logic [OPW-1:0] OP_ADD_L  = 6'b110000;
  localparam logic [OPW-1:0] OP_AND_R  = 6'b001010;
  localparam logic [OPW-1:0] OP_AND_L  = 6'b110110;
  localparam logic [OPW-1:0] OP_CMP_R  = 6'b001111;
  localparam logic [OPW-1:0] OP_CMP_S  = 6'b010011;

  // flag bit positions inside the 4-bit flag word
  localparam int unsigned FL_CY = 3;
  localparam int unsigned FL_OV = 2;
  localparam int unsigned FL_S  = 1;
  localparam int unsigned FL_Z  = 0;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_AND = 2'd2,
    K_BAD = 2'd3
  } alu_kind_e;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  parameter int unsigned HWW  = 16
) (
  input  logic [HWW-1:0]  hw0,
  input  logic [HWW-1:0]  hw1,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output alu_kind_e       kind,
  output logic [XLEN-1:0] opnd_x,
  output logic [XLEN-1:0] opnd_y,
  output logic [IDXW-1:0] dest_idx,
  output logic            wants_write
);
  localparam int unsigned OP_LO = IDXW;
  localparam int unsigned OP_HI = IDXW + OPW - 1;

  logic [OPW-1:0]  opcode;
  logic [IDXW-1:0] short_imm;
  logic [XLEN-1:0] short_sx;
  logic [XLEN-1:0] long_sx;
  logic [XLEN-1:0] long_zx;

  assign opcode    = hw0[OP_HI:OP_LO];
  assign short_imm = hw0[IDXW-1:0];
  assign dest_idx  = hw0[HWW-1:HWW-IDXW];
  assign short_sx  = {{(XLEN-IDXW){short_imm[IDXW-1]}}, short_imm};
  assign long_sx   = {{(XLEN-HWW){hw1[HWW-1]}}, hw1};
  assign long_zx   = {{(XLEN-HWW){1'b0}}, hw1};

  always_comb begin
    kind        = K_BAD;
    opnd_x      = rs2_val;
    opnd_y      = rs1_val;
    wants_write = 1'b0;
    unique case (opcode)
      OP_ADD_R: begin kind = K_ADD; wants_write = 1'b1; end
      OP_ADD_S: begin kind = K_ADD; opnd_y = short_sx; wants_write = 1'b1; end
      OP_ADD_L: begin kind = K_ADD; opnd_x = rs1_val; opnd_y = long_sx; wants_write = 1'b1; end
      OP_AND_R: begin kind = K_AND; wants_write = 1'b1; end
      OP_AND_L: begin kind = K_AND; opnd_x = rs1_val; opnd_y = long_zx; wants_write = 1'b1; end
      OP_CMP_R: begin kind = K_SUB; end
      OP_CMP_S: begin kind = K_SUB; opnd_y = short_sx; end
      default:  begin kind = K_BAD; end
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_kind_e       kind,
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  logic [3:0]      flags_in,
  output logic [XLEN-1:0] result,
  output logic [3:0]      flags_out
);
  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0] sum_w;
  logic [XLEN:0] dif_w;
  logic          add_ov;
  logic          sub_ov;

  assign sum_w  = {1'b0, x} + {1'b0, y};
  assign dif_w  = {1'b0, x} - {1'b0, y};
  assign add_ov = (x[MSB] == y[MSB]) && (sum_w[MSB] != x[MSB]);
  assign sub_ov = (x[MSB] != y[MSB]) && (dif_w[MSB] != x[MSB]);

  always_comb begin
    result    = '0;
    flags_out = flags_in;
    unique case (kind)
      K_ADD: begin
        result           = sum_w[XLEN-1:0];
        flags_out[FL_CY] = sum_w[XLEN];
        flags_out[FL_OV] = add_ov;
      end
      K_SUB: begin
        result           = dif_w[XLEN-1:0];
        flags_out[FL_CY] = dif_w[XLEN];
        flags_out[FL_OV] = sub_ov;
      end
      K_AND: begin
        result           = x & y;
        flags_out[FL_OV] = 1'b0;
      end
      default: begin
        result = '0;
      end
    endcase
    if (kind != K_BAD) begin
      flags_out[FL_S] = result[MSB];
      flags_out[FL_Z] = (result == '0);
    end
  end
endmodule

// File: rtl/exec_outstage.sv
module exec_outstage #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            drain,
  input  logic            nxt_we,
  input  logic [IDXW-1:0] nxt_idx,
  input  logic [XLEN-1:0] nxt_data,
  input  logic            nxt_ill,
  input  logic [3:0]      nxt_flags,
  output logic            vld,
  output logic            we,
  output logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] data,
  output logic            ill,
  output logic [3:0]      flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      we    <= 1'b0;
      idx   <= '0;
      data  <= '0;
      ill   <= 1'b0;
      flags <= '0;
    end else if (take) begin
      vld  <= 1'b1;
      we   <= nxt_we;
      idx  <= nxt_idx;
      data <= nxt_data;
      ill  <= nxt_ill;
      if (!nxt_ill) flags <= nxt_flags;
    end else if (drain) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/exec_unit_top.sv
module exec_unit_top
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  parameter int unsigned HWW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HWW-1:0]  in_hw0,
  input  logic [HWW-1:0]  in_hw1,
  input  logic [XLEN-1:0] in_rs1_val,
  input  logic [XLEN-1:0] in_rs2_val,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_wr_en,
  output logic [IDXW-1:0] out_wr_idx,
  output logic [XLEN-1:0] out_wr_data,
  output logic            out_illegal,
  output logic [3:0]      out_flags
);
  alu_kind_e       kind;
  logic [XLEN-1:0] opnd_x;
  logic [XLEN-1:0] opnd_y;
  logic [IDXW-1:0] dest_idx;
  logic            wants_write;
  logic [XLEN-1:0] alu_res;
  logic [3:0]      alu_flags;
  logic            take;
  logic            is_bad;
  logic            do_write;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign is_bad   = (kind == K_BAD);
  assign do_write = wants_write && (dest_idx != '0);

  exec_decode #(.XLEN(XLEN), .IDXW(IDXW), .HWW(HWW)) u_dec (
    .hw0(in_hw0), .hw1(in_hw1), .rs1_val(in_rs1_val), .rs2_val(in_rs2_val),
    .kind(kind), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .dest_idx(dest_idx), .wants_write(wants_write)
  );

  exec_alu #(.XLEN(XLEN)) u_alu (
    .kind(kind), .x(opnd_x), .y(opnd_y), .flags_in(out_flags),
    .result(alu_res), .flags_out(alu_flags)
  );

  exec_outstage #(.XLEN(XLEN), .IDXW(IDXW)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .drain(out_ready),
    .nxt_we(do_write), .nxt_idx(dest_idx), .nxt_data(alu_res),
    .nxt_ill(is_bad), .nxt_flags(alu_flags),
    .vld(out_valid), .we(out_wr_en), .idx(out_wr_idx), .data(out_wr_data),
    .ill(out_illegal), .flags(out_flags)
  );
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  parameter int unsigned HWW  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [HWW-1:0]  in_hw0,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_wr_en,
  input logic [IDXW-1:0] out_wr_idx,
  input logic [XLEN-1:0] out_wr_data,
  input logic            out_illegal,
  input logic [3:0]      out_flags
);
  localparam int unsigned OP_LO = IDXW;
  localparam int unsigned OP_HI = IDXW + OPW - 1;

  logic [OPW-1:0] opc;
  logic           acc;
  logic           opc_known;
  logic           opc_cmp;

  assign opc       = in_hw0[OP_HI:OP_LO];
  assign acc       = in_valid && in_ready;
  assign opc_cmp   = (opc == OP_CMP_R) || (opc == OP_CMP_S);
  assign opc_known = opc_cmp || (opc == OP_ADD_R) || (opc == OP_ADD_S) ||
                     (opc == OP_ADD_L) || (opc == OP_AND_R) || (opc == OP_AND_L);

  // R10: empty output slot always accepts
  p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10: stalled packet and flags stay put
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_wr_data) &&
      $stable(out_wr_idx) && $stable(out_wr_en) && $stable(out_flags)));

  // R10: accepted instruction gives a packet next cycle
  p_accept_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R8: index 0 never written
  p_no_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_idx == '0) |-> !out_wr_en);

  // R9: illegal packet writes nothing
  p_illegal_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_wr_en);

  // R9: unknown opcode keeps flags
  p_illegal_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !opc_known) |=> (out_illegal && $stable(out_flags)));

  // R5: compare never writes
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opc_cmp) |=> (!out_wr_en && !out_illegal));
endmodule

bind exec_unit_top exec_unit_chk #(.XLEN(XLEN), .IDXW(IDXW), .HWW(HWW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_hw0(in_hw0), .out_valid(out_valid), .out_ready(out_ready),
  .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data),
  .out_illegal(out_illegal), .out_flags(out_flags)
);

// File: tb/exec_unit_top_test.sv
module exec_unit_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic [4:0]  r2;
    logic [5:0]  op;
    logic [4:0]  r1;
    logic [15:0] hw1;
    logic [31:0] a;     // rs1 value
    logic [31:0] b;     // rs2 value
    logic        we;
    logic [31:0] d;
    logic        ill;
    logic [3:0]  fl;    // {CY,OV,S,Z}
    logic [7:0]  req;
  } vec_t;

  // flags carry across rows: AND rows depend on the CY left by the row before
  localparam vec_t VECS [NVEC] = '{
    '{5'd3,  6'b001110, 5'd1,  16'h0000, 32'h0000_0005, 32'h0000_0007, 1'b1, 32'h0000_000C, 1'b0, 4'b0000, 8'd1}, // R1
    '{5'd4,  6'b001110, 5'd1,  16'h0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 4'b1001, 8'd6}, // R6 carry+zero
    '{5'd5,  6'b001110, 5'd1,  16'h0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 32'h8000_0000, 1'b0, 4'b0110, 8'd6}, // R6 overflow
    '{5'd6,  6'b010010, 5'h1F, 16'h0000, 32'h0000_0000, 32'h0000_000A, 1'b1, 32'h0000_0009, 1'b0, 4'b1000, 8'd2}, // R2 imm -1
    '{5'd7,  6'b110000, 5'd2,  16'h8000, 32'h0000_0100, 32'h0000_0000, 1'b1, 32'hFFFF_8100, 1'b0, 4'b0010, 8'd3}, // R3 sext
    '{5'd8,  6'b001111, 5'd1,  16'h0000, 32'h0000_0005, 32'h0000_0003, 1'b0, 32'h0,         1'b0, 4'b1010, 8'd5}, // R5 borrow
    '{5'd9,  6'b001010, 5'd1,  16'h0000, 32'hF0F0_00FF, 32'h0FF0_FF0F, 1'b1, 32'h00F0_000F, 1'b0, 4'b1000, 8'd7}, // R7 CY kept
    '{5'd10, 6'b110110, 5'd1,  16'hFFFF, 32'h8000_1234, 32'h0000_0000, 1'b1, 32'h0000_1234, 1'b0, 4'b1000, 8'd4}, // R4 zext
    '{5'd8,  6'b010011, 5'd5,  16'h0000, 32'h0000_0000, 32'h0000_0005, 1'b0, 32'h0,         1'b0, 4'b0001, 8'd5}, // R5 imm equal
    '{5'd8,  6'b001111, 5'd1,  16'h0000, 32'h0000_0001, 32'h8000_0000, 1'b0, 32'h0,         1'b0, 4'b0100, 8'd6}, // R6 sub ov
    '{5'd11, 6'b001010, 5'd1,  16'h0000, 32'h0000_000F, 32'h0000_00F0, 1'b1, 32'h0000_0000, 1'b0, 4'b0001, 8'd7}, // R7 OV cleared
    '{5'd0,  6'b001110, 5'd1,  16'h0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 4'b1001, 8'd8}, // R8 dest 0
    '{5'd12, 6'b111111, 5'd1,  16'h0000, 32'h0000_0003, 32'h0000_0004, 1'b0, 32'h0,         1'b1, 4'b1001, 8'd9}, // R9
    '{5'd13, 6'b000000, 5'd1,  16'h0000, 32'h0000_0003, 32'h0000_0004, 1'b0, 32'h0,         1'b1, 4'b1001, 8'd9}, // R9
    '{5'd14, 6'b010010, 5'h0F, 16'h0000, 32'h0000_0000, 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'b0010, 8'd2}, // R2 imm +15
    '{5'd15, 6'b110000, 5'd3,  16'h0001, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 32'h8000_0000, 1'b0, 4'b0110, 8'd3}  // R3 overflow
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_hw0 = '0;
  logic [15:0] in_hw1 = '0;
  logic [31:0] in_rs1_val = '0;
  logic [31:0] in_rs2_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wr_en;
  logic [4:0]  out_wr_idx;
  logic [31:0] out_wr_data;
  logic        out_illegal;
  logic [3:0]  out_flags;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_unit_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hw0(in_hw0), .in_hw1(in_hw1), .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr_en(out_wr_en),
    .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data), .out_illegal(out_illegal),
    .out_flags(out_flags)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] r2, input logic [5:0] op, input logic [4:0] r1,
                       input logic [15:0] h1, input logic [31:0] a, input logic [31:0] b);
    in_hw0     = {r2, op, r1};
    in_hw1     = h1;
    in_rs1_val = a;
    in_rs2_val = b;
    in_valid   = 1'b1;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R11", "flags in reset", {28'b0, out_flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "in_ready when empty", {31'b0, in_ready}, 32'd1);

    // table walk: drive at negedge, accept at posedge, check next negedge
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d#%0d", VECS[i].req, i);
      out_ready = 1'b1;
      drive(VECS[i].r2, VECS[i].op, VECS[i].r1, VECS[i].hw1, VECS[i].a, VECS[i].b);
      @(posedge clk);
      @(negedge clk);
      check(tag, "out_valid", {31'b0, out_valid}, 32'd1);
      check(tag, "wr_en", {31'b0, out_wr_en}, {31'b0, VECS[i].we});
      check(tag, "illegal", {31'b0, out_illegal}, {31'b0, VECS[i].ill});
      check(tag, "flags", {28'b0, out_flags}, {28'b0, VECS[i].fl});
      if (VECS[i].we) begin
        check(tag, "wr_idx", {27'b0, out_wr_idx}, {27'b0, VECS[i].r2});
        check(tag, "wr_data", out_wr_data, VECS[i].d);
      end
    end

    // R10: drain, then back-pressure
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", "drained", {31'b0, out_valid}, 32'd0);
    drive(5'd3, 6'b001110, 5'd1, 16'h0, 32'd1, 32'd1);
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", "held valid", {31'b0, out_valid}, 32'd1);
    check("R10", "held data", out_wr_data, 32'd2);
    check("R10", "in_ready stalled", {31'b0, in_ready}, 32'd0);
    drive(5'd4, 6'b001110, 5'd1, 16'h0, 32'h1, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R10", "stall data stable", out_wr_data, 32'd2);
    check("R10", "stall idx stable", {27'b0, out_wr_idx}, 32'd3);
    check("R10", "stall flags stable", {28'b0, out_flags}, {28'b0, 4'b0000});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "second data", out_wr_data, 32'd0);
    check("R10", "second idx", {27'b0, out_wr_idx}, 32'd4);
    check("R6", "second flags", {28'b0, out_flags}, {28'b0, 4'b1001});
    @(posedge clk);
    @(negedge clk);
    check("R10", "empty after drain", {31'b0, out_valid}, 32'd0);

    // R11: reset mid-run clears flags
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", "flags after reset", {28'b0, out_flags}, 32'd0);
    check("R11", "valid after reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule